// File: doc/BRIEF.md
# HDLC Interrupt Status Unit

This block collects what happens in an HDLC transmitter, an HDLC receiver and their two FIFOs into one 8-bit status word. A processor reads that word through a small register port, and an 8-bit enable word decides which status bits may raise a single active-high interrupt line. Most status bits are sticky: they hold an event until the processor reads the status word, and that read clears them. The two FIFO threshold bits can instead show the live comparison when a dynamic mode input is high.

The block also changes its behaviour in transparent (unframed) mode. There, frame events do not exist, and transmit-done reports the transmit FIFO draining empty. A pending underrun-abort bit drives a transmit-inhibit output, which holds the transmitter until software has seen the abort. The receive line is watched bit by bit for a run of ones that marks an idle receiver.

The only stream is the received bit input. It is qualified by `rx_bit_valid` and is always accepted, so there is no ready and no back-pressure: a bit is consumed in every cycle in which valid is high. All other pins are plain control and status signals.

Top module: `hdlc_irq_status`

## Requirements
- R1: The status word bits are, from bit 7 down to bit 0: reserved (reads 0), receiver idle, receive overrun, receive end-of-frame, receive full, underrun abort, transmit empty, transmit done. After reset the word is 0x02 and the enable word is 0x00.
- R2: `irq` is high one cycle after any status bit that reads 1 has its enable bit (same position) at 1, and is low otherwise.
- R3: With transparent mode off, a frame-sent or abort-sent pulse sets transmit done (bit 0).
- R4: With transparent mode on, transmit done sets when `tx_level` goes from nonzero to 0, or on a `tx_reset` pulse. Frame-sent and abort-sent pulses have no effect.
- R5: A status read (`cpu_sel`=1, `cpu_wr`=0, `cpu_addr`=0) clears every latched bit in the following cycle.
- R6: With dynamic mode off, transmit empty latches while `tx_level` <= `tx_empty_thr`, and receive full latches while `rx_level` >= `rx_full_thr`. Both are sticky and clear on read.
- R7: With dynamic mode on, bits 1 and 3 show the live threshold comparisons in the same cycle, and a read has no effect on them.
- R8: With transparent mode on, underrun-abort and receive end-of-frame pulses are ignored.
- R9: `tx_inhibit` is high while the underrun-abort bit (bit 2) is set, and it falls in the cycle after the read that clears the bit.
- R10: Receiver idle (bit 6) sets on the 15th consecutive valid 1 bit, only once per run of ones. A valid 0 bit starts a new run.
- R11: An event that arrives in the same cycle as a status read is set after that read.
- R12: A write with `cpu_addr`=1 loads the enable word, and `cpu_rdata` shows the enable word while `cpu_addr`=1 and the status word while `cpu_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_frame_sent | input | 1 | Pulse: closing flag fully sent |
| ev_abort_sent | input | 1 | Pulse: abort sequence fully sent |
| ev_underrun_abort | input | 1 | Pulse: abort sent because of a transmit underrun |
| ev_rx_eof | input | 1 | Pulse: receiver finished a frame |
| ev_rx_overrun | input | 1 | Pulse: receive FIFO overran |
| rx_bit_valid | input | 1 | Received bit is valid this cycle |
| rx_bit | input | 1 | Received line bit |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_empty_thr | input | LVL_W | Transmit empty threshold |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_full_thr | input | LVL_W | Receive full threshold |
| transparent | input | 1 | Transparent (unframed) mode |
| dyn_mode | input | 1 | Live threshold bits |
| tx_reset | input | 1 | Pulse: transmitter reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 1 | 0 = status word, 1 = enable word |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed word |
| irq | output | 1 | Registered interrupt line |
| tx_inhibit | output | 1 | Holds off transmission of new data |

## Verification
The assertions take every event input to be a single-cycle pulse that is sampled on the clock edge, and take a read to be any cycle in which the strobe is high with the write flag low. They also take the mode inputs as sampled in the same cycle as the events they qualify. The bench changes every input only on the falling edge, so each set of values is stable across one rising edge. Random cycles mix all pulses, reads, enable writes and mode changes freely, including reads that meet an event in the same cycle and level sweeps across both thresholds. A bench model recomputes the status word, the interrupt line and the inhibit from the requirements in every cycle.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
  localparam int STAT_W   = 8;
  localparam int LATCH_W  = 7;
  // bit positions of the status word (software decodes these)
  localparam int B_TDONE  = 0;
  localparam int B_TEMPTY = 1;
  localparam int B_UNDABT = 2;
  localparam int B_RFULL  = 3;
  localparam int B_REOF   = 4;
  localparam int B_ROVR   = 5;
  localparam int B_RIDLE  = 6;
  localparam int B_RSVD   = 7;
  localparam int IDLE_RUN = 15;
endpackage

// File: rtl/hdlc_sticky_bit.sv
module hdlc_sticky_bit #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear so an event meeting a read is kept
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= RST_VAL;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/hdlc_ones_run.sv
module hdlc_ones_run #(
  parameter int RUN_LEN = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_val,
  output logic hit_o
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (bit_valid) begin
      if (!bit_val)          run_q <= '0;
      else if (run_q != FULL) run_q <= run_q + 1'b1;
    end
  end

  // one pulse per run: only the step onto the saturated count
  assign hit_o = bit_valid && bit_val && (run_q == LAST);
endmodule

// File: rtl/hdlc_thresh_cmp.sv
module hdlc_thresh_cmp #(
  parameter int LVL_W    = 6,
  parameter bit AT_ABOVE = 1'b0
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             hit_o
);
  generate
    if (AT_ABOVE) begin : g_ge
      assign hit_o = (lvl_i >= thr_i);
    end else begin : g_le
      assign hit_o = (lvl_i <= thr_i);
    end
  endgenerate
endmodule

// File: rtl/hdlc_irq_status.sv
module hdlc_irq_status
  import hdlc_irq_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_frame_sent,
  input  logic             ev_abort_sent,
  input  logic             ev_underrun_abort,
  input  logic             ev_rx_eof,
  input  logic             ev_rx_overrun,
  input  logic             rx_bit_valid,
  input  logic             rx_bit,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_empty_thr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_full_thr,
  input  logic             transparent,
  input  logic             dyn_mode,
  input  logic             tx_reset,
  input  logic             cpu_sel,
  input  logic             cpu_wr,
  input  logic             cpu_addr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  output logic             irq,
  output logic             tx_inhibit
);
  logic               rd_stat;
  logic               wr_en;
  logic               te_live;
  logic               rf_live;
  logic               idle_hit;
  logic               tx_zero_q;
  logic               tx_drained;
  logic [LATCH_W-1:0] set_vec;
  logic [LATCH_W-1:0] latch_q;
  logic [STAT_W-1:0]  stat_view;
  logic [STAT_W-1:0]  enable_q;

  assign rd_stat = cpu_sel && !cpu_wr && !cpu_addr;
  assign wr_en   = cpu_sel &&  cpu_wr &&  cpu_addr;

  hdlc_thresh_cmp #(.LVL_W(LVL_W), .AT_ABOVE(1'b0)) u_te_cmp (
    .lvl_i(tx_level), .thr_i(tx_empty_thr), .hit_o(te_live));

  hdlc_thresh_cmp #(.LVL_W(LVL_W), .AT_ABOVE(1'b1)) u_rf_cmp (
    .lvl_i(rx_level), .thr_i(rx_full_thr), .hit_o(rf_live));

  hdlc_ones_run #(.RUN_LEN(IDLE_RUN)) u_idle (
    .clk(clk), .rst_n(rst_n), .bit_valid(rx_bit_valid),
    .bit_val(rx_bit), .hit_o(idle_hit));

  // transmit FIFO drain edge for transparent mode
  always_ff @(posedge clk) begin
    if (!rst_n) tx_zero_q <= 1'b1;
    else        tx_zero_q <= (tx_level == '0);
  end
  assign tx_drained = (tx_level == '0) && !tx_zero_q;

  always_comb begin
    set_vec           = '0;
    set_vec[B_TDONE]  = transparent ? (tx_drained || tx_reset)
                                    : (ev_frame_sent || ev_abort_sent);
    set_vec[B_TEMPTY] = te_live;
    set_vec[B_UNDABT] = ev_underrun_abort && !transparent;
    set_vec[B_RFULL]  = rf_live;
    set_vec[B_REOF]   = ev_rx_eof && !transparent;
    set_vec[B_ROVR]   = ev_rx_overrun;
    set_vec[B_RIDLE]  = idle_hit;
  end

  genvar gi;
  generate
    for (gi = 0; gi < LATCH_W; gi++) begin : g_bit
      hdlc_sticky_bit #(.RST_VAL(gi == B_TEMPTY)) u_bit (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec[gi]),
        .clr_i(rd_stat), .q_o(latch_q[gi]));
    end
  endgenerate

  always_comb begin
    stat_view           = {1'b0, latch_q};
    stat_view[B_TEMPTY] = dyn_mode ? te_live : latch_q[B_TEMPTY];
    stat_view[B_RFULL]  = dyn_mode ? rf_live : latch_q[B_RFULL];
    stat_view[B_RSVD]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     enable_q <= '0;
    else if (wr_en) enable_q <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(stat_view & enable_q);
  end

  assign cpu_rdata  = cpu_addr ? enable_q : stat_view;
  assign tx_inhibit = latch_q[B_UNDABT];
endmodule

// File: rtl/hdlc_irq_status_chk.sv
module hdlc_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stat,
  input logic       transparent,
  input logic       ev_underrun_abort,
  input logic       ev_rx_overrun,
  input logic [7:0] stat_view,
  input logic [7:0] enable_q,
  input logic [7:0] cpu_rdata,
  input logic       cpu_addr,
  input logic       irq,
  input logic       tx_inhibit
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr |-> !cpu_rdata[7]);

  assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == 8'h00) |=> !irq);

  assert_eof_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (transparent && !stat_view[4]) |=> !stat_view[4]);

  assert_inhibit_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_underrun_abort && !transparent) |=> tx_inhibit);

  assert_inhibit_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_inhibit && !rd_stat) |=> tx_inhibit);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ev_rx_overrun) |=> !stat_view[5]);

  assert_event_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ev_rx_overrun) |=> stat_view[5]);
endmodule

bind hdlc_irq_status hdlc_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .transparent(transparent),
  .ev_underrun_abort(ev_underrun_abort), .ev_rx_overrun(ev_rx_overrun),
  .stat_view(stat_view), .enable_q(enable_q), .cpu_rdata(cpu_rdata),
  .cpu_addr(cpu_addr), .irq(irq), .tx_inhibit(tx_inhibit));

// File: tb/sim_hdlc_irq_status.sv
module sim_hdlc_irq_status;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 0, as_ = 0, ua = 0, reof = 0, rovr = 0, bv = 0, bt = 0;
  logic [LW-1:0] txl = 20, txt = 4, rxl = 0, rxt = 10;
  logic trans = 0, dyn = 0, txr = 0, sel = 0, wr = 0, addr = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata;
  logic irq, inh;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // bench model state
  bit tdone_m, te_m, und_m, rf_m, eof_m, ovr_m, ridl_m, zq_m, irq_m;
  bit [7:0] en_m;
  int run_m;

  always #2 clk = ~clk;  // 250 MHz

  hdlc_irq_status #(.LVL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_frame_sent(fs), .ev_abort_sent(as_),
    .ev_underrun_abort(ua), .ev_rx_eof(reof), .ev_rx_overrun(rovr),
    .rx_bit_valid(bv), .rx_bit(bt), .tx_level(txl), .tx_empty_thr(txt),
    .rx_level(rxl), .rx_full_thr(rxt), .transparent(trans), .dyn_mode(dyn),
    .tx_reset(txr), .cpu_sel(sel), .cpu_wr(wr), .cpu_addr(addr),
    .cpu_wdata(wd), .cpu_rdata(rdata), .irq(irq), .tx_inhibit(inh));

  function automatic bit [7:0] view_m();
    bit te_l = (txl <= txt);
    bit rf_l = (rxl >= rxt);
    return {1'b0, ridl_m, ovr_m, eof_m, dyn ? rf_l : rf_m, und_m,
            dyn ? te_l : te_m, tdone_m};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_pulses();
    fs = 0; as_ = 0; ua = 0; reof = 0; rovr = 0; txr = 0;
    sel = 0; wr = 0; bv = 0;
  endtask

  // inputs are set just after a falling edge; check, then advance one clock
  task automatic tick(input string tag);
    bit [7:0] v;
    bit rd, hit, drained, tset;
    #1;
    v = view_m();
    chk(tag, "rdata", rdata, addr ? en_m : v);
    chk(tag, "irq", {7'b0, irq}, {7'b0, irq_m});
    chk(tag, "inhibit", {7'b0, inh}, {7'b0, und_m});
    rd = sel && !wr && !addr;
    hit = bv && bt && (run_m == 14);
    drained = (txl == 0) && !zq_m;
    tset = trans ? (drained || txr) : (fs || as_);
    @(posedge clk);
    irq_m   = |(v & en_m);
    tdone_m = tset || (tdone_m && !rd);
    te_m    = (txl <= txt) || (te_m && !rd);
    rf_m    = (rxl >= rxt) || (rf_m && !rd);
    und_m   = (ua && !trans) || (und_m && !rd);
    eof_m   = (reof && !trans) || (eof_m && !rd);
    ovr_m   = rovr || (ovr_m && !rd);
    ridl_m  = hit || (ridl_m && !rd);
    zq_m    = (txl == 0);
    if (bv) run_m = bt ? ((run_m < 15) ? run_m + 1 : 15) : 0;
    if (sel && wr && addr) en_m = wd;
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic rd_status(input string tag);
    sel = 1; wr = 0; addr = 0; tick(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tdone_m = 0; te_m = 1; und_m = 0; rf_m = 0; eof_m = 0; ovr_m = 0;
    ridl_m = 0; zq_m = 1; irq_m = 0; en_m = 0; run_m = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset word 0x02, reserved bit 0
    tick("R1");
    addr = 1; tick("R1");
    // R12: enable write and readback
    sel = 1; wr = 1; addr = 1; wd = 8'hFF; tick("R12");
    addr = 1; tick("R12");
    addr = 0;
    // R2: transmit empty pending with full enables raises irq
    tick("R2"); tick("R2");
    // R5: read clears, irq drops a cycle later
    rd_status("R5"); tick("R5"); tick("R2");
    // R3: frame and abort sent
    fs = 1; tick("R3"); tick("R3"); rd_status("R3");
    as_ = 1; tick("R3"); tick("R3"); rd_status("R3");
    // R11: overrun meeting a read
    rovr = 1; sel = 1; wr = 0; addr = 0; tick("R11"); tick("R11");
    rd_status("R11"); tick("R11");
    // R9: underrun abort inhibits until read
    ua = 1; tick("R9"); tick("R9"); tick("R9"); rd_status("R9"); tick("R9");
    // R8: transparent ignores underrun and end-of-frame
    trans = 1; ua = 1; reof = 1; tick("R8"); tick("R8");
    // R4: drain to zero, frame sent ignored, tx_reset
    txl = 5; fs = 1; tick("R4"); txl = 0; tick("R4"); tick("R4");
    rd_status("R4"); tick("R4"); txr = 1; tick("R4"); tick("R4");
    rd_status("R4"); txl = 20; trans = 0;
    // R6: latched thresholds
    txl = 3; rxl = 12; tick("R6"); rd_status("R6"); tick("R6");
    txl = 20; rxl = 0; tick("R6"); rd_status("R6"); tick("R6");
    // R7: live thresholds ignore reads
    dyn = 1; rxl = 12; tick("R7"); rd_status("R7"); tick("R7");
    rxl = 2; tick("R7"); txl = 1; tick("R7"); txl = 30; tick("R7");
    dyn = 0; rd_status("R7"); rd_status("R7");
    // R10: idle after 15 ones, once per run
    for (int i = 0; i < 14; i++) begin bv = 1; bt = 1; tick("R10"); end
    tick("R10");
    bv = 1; bt = 1; tick("R10"); tick("R10");
    rd_status("R10");
    for (int i = 0; i < 5; i++) begin bv = 1; bt = 1; tick("R10"); end
    bv = 1; bt = 0; tick("R10");
    for (int i = 0; i < 15; i++) begin bv = 1; bt = 1; tick("R10"); end
    tick("R10");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      fs = ($urandom % 8) == 0;  as_ = ($urandom % 16) == 0;
      ua = ($urandom % 16) == 0; reof = ($urandom % 8) == 0;
      rovr = ($urandom % 10) == 0; txr = ($urandom % 20) == 0;
      bv = ($urandom % 2) == 0;  bt = ($urandom % 8) != 0;
      if (($urandom % 32) == 0) trans = ~trans;
      if (($urandom % 32) == 0) dyn = ~dyn;
      txl = LW'($urandom % 24); rxl = LW'($urandom % 24);
      if (($urandom % 64) == 0) begin txt = LW'($urandom); rxt = LW'($urandom); end
      sel = ($urandom % 3) == 0; wr = ($urandom % 6) == 0;
      addr = wr ? 1'b1 : (($urandom % 5) == 0);
      wd = 8'($urandom);
      tick("R5");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule